// File: doc/BRIEF.md
# Serial Bus Pause Controller

This block sits in front of the shift logic of a serial flash slave and decides when a transfer is paused. It watches three pins: the active-low pause pin, the active-low chip select and the serial clock. All three are sampled by a fast system clock through synchronizer chains. From these it produces a pause flag, the data-output high-impedance control and qualified rising and falling serial-clock events. The downstream shift and command logic only advances on the qualified events. Because nothing is cleared during a pause, a partly shifted instruction or a partly filled data buffer resumes where it stopped. A one-cycle deselect pulse tells the command logic to discard its state when chip select is released, and this also applies in the middle of a pause.

The pause takes effect at once or is deferred, depending on the serial clock level. If the serial clock is low when the pause pin falls, the pause begins at once. If the clock is high, the pause begins only after the next falling clock edge, and that edge is still forwarded. Release follows the same rule: it is immediate with the clock low, and otherwise it waits for the next falling edge, which is swallowed.

The state machine has five states:
- `PS_IDLE`: deselected.
- `PS_RUN`: selected, not paused.
- `PS_ARM`: entry pending, waiting for a clock fall.
- `PS_HELD`: paused.
- `PS_RELEASE`: exit pending, waiting for a clock fall.

Its transitions are:
- **Select**: `PS_IDLE` to `PS_RUN`, when chip select goes low.
- **Enter now**: `PS_RUN` to `PS_HELD`, when the pause pin falls with the clock low.
- **Arm**: `PS_RUN` to `PS_ARM`, when the pause pin falls with the clock high.
- **Cancel**: `PS_ARM` to `PS_RUN`, when the pause pin rises.
- **Enter late**: `PS_ARM` to `PS_HELD`, on a clock fall.
- **Leave now**: `PS_HELD` to `PS_RUN`, when the pause pin rises with the clock low.
- **Release**: `PS_HELD` to `PS_RELEASE`, when the pause pin rises with the clock high.
- **Re-pause**: `PS_RELEASE` to `PS_HELD`, when the pause pin falls.
- **Leave late**: `PS_RELEASE` to `PS_RUN`, on a clock fall.
- **Drop**: any state to `PS_IDLE`, when chip select goes high.

Top module: `pause_ctrl`

## Requirements
- R1: After reset, pause_on is 0, do_hiz is 1 and no qualified clock event or sel_drop pulse is produced.
- R2: While chip select (cs_n_pin, 1 = deselected) is high, a falling pause pin never sets pause_on.
- R3: When selected and hold_n_pin falls with sck_pin low, pause_on becomes 1 within 4 system clock cycles.
- R4: When selected and hold_n_pin falls with sck_pin high, pause_on stays 0 until sck_pin falls. That fall is forwarded as exactly one sck_fall_en pulse, and pause_on becomes 1 afterwards.
- R5: When paused and hold_n_pin rises with sck_pin low, pause_on returns to 0 within 4 system clock cycles.
- R6: When paused and hold_n_pin rises with sck_pin high, pause_on stays 1 until sck_pin falls. That fall produces no sck_fall_en pulse, and pause_on clears afterwards.
- R7: While pause_on is 1, sck_rise_en and sck_fall_en stay 0 and do_hiz is 1.
- R8: A rise of hold_n_pin while an entry is pending cancels the entry, so a later sck_pin fall does not start a pause.
- R9: A fall of hold_n_pin while an exit is pending keeps the pause, so a later sck_pin fall does not end it.
- R10: A rise of cs_n_pin produces exactly one sel_drop pulse, and pause_on is 0 in that same cycle, whatever the level of hold_n_pin.
- R11: While selected and not paused, do_hiz is 0, and each sck_pin rise and fall gives exactly one sck_rise_en or sck_fall_en pulse.
- R12: Selecting the device while hold_n_pin is already low does not start a pause; only a later fall of hold_n_pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_n_pin | input | 1 | Active-low pause pin, asynchronous |
| cs_n_pin | input | 1 | Active-low chip select pin, asynchronous |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| pause_on | output | 1 | Pause in effect |
| do_hiz | output | 1 | 1 puts the serial data output in high impedance |
| sck_rise_en | output | 1 | One-cycle qualified serial clock rising event |
| sck_fall_en | output | 1 | One-cycle qualified serial clock falling event |
| sel_drop | output | 1 | One-cycle pulse on deselect; clears the command state |

## Verification
The bench targets the two deferred paths, where the clock is high at the pause pin edge.

- A design that acts at once on the entry path would swallow the clock fall that should still shift data out.
- A design that acts at once on the exit path would let a stray falling edge through.

The bench also covers a pause pin bounce while an entry or exit is pending. A wrong design there would either pause late or resume early. Finally, it covers deselecting during a pause, and selecting with the pause pin already low. A wrong design in these cases would keep the output tri-stated after deselect, or treat a level as an edge.

// File: rtl/pause_pkg.sv
package pause_pkg;

    typedef enum logic [2:0] {
        PS_IDLE    = 3'd0,
        PS_RUN     = 3'd1,
        PS_ARM     = 3'd2,
        PS_HELD    = 3'd3,
        PS_RELEASE = 3'd4
    } pause_st_t;

    // bit positions of the pin bundle
    localparam int PIN_SCK  = 0;
    localparam int PIN_CS   = 1;
    localparam int PIN_HOLD = 2;
    localparam int PIN_W    = 3;

    // pin level after reset: clock low, deselected, not paused
    localparam logic [PIN_W-1:0] PIN_IDLE = 3'b110;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int            W       = 3,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[LAST];
endmodule

// File: rtl/pin_edge.sv
module pin_edge #(
    parameter int            W       = 3,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/pause_fsm.sv
module pause_fsm
    import pause_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_lvl,
    input  logic sck_lvl,
    input  logic hold_rise,
    input  logic hold_fall,
    input  logic sck_fall,
    input  logic cs_fall,
    output logic held,
    output pause_st_t state
);
    pause_st_t nxt;

    always_comb begin
        nxt = state;
        if (cs_n_lvl) begin
            nxt = PS_IDLE;
        end else begin
            unique case (state)
                PS_IDLE: begin
                    if (cs_fall || !cs_n_lvl) nxt = PS_RUN;
                end
                PS_RUN: begin
                    if (hold_fall) nxt = sck_lvl ? PS_ARM : PS_HELD;
                end
                PS_ARM: begin
                    if (hold_rise)     nxt = PS_RUN;
                    else if (sck_fall) nxt = PS_HELD;
                end
                PS_HELD: begin
                    if (hold_rise) nxt = sck_lvl ? PS_RELEASE : PS_RUN;
                end
                PS_RELEASE: begin
                    if (hold_fall)     nxt = PS_HELD;
                    else if (sck_fall) nxt = PS_RUN;
                end
                default: nxt = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            PS_HELD, PS_RELEASE: held = !cs_n_lvl;
            default:             held = 1'b0;
        endcase
    end
endmodule

// File: rtl/pause_ctrl.sv
module pause_ctrl
    import pause_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_n_pin,
    input  logic cs_n_pin,
    input  logic sck_pin,
    output logic pause_on,
    output logic do_hiz,
    output logic sck_rise_en,
    output logic sck_fall_en,
    output logic sel_drop
);
    logic [PIN_W-1:0] pins_raw;
    logic [PIN_W-1:0] pins_s;
    logic [PIN_W-1:0] pins_r;
    logic [PIN_W-1:0] pins_f;
    logic             hold_s;
    logic             cs_n_s;
    logic             sck_s;
    logic             held;
    pause_st_t        state;

    assign pins_raw[PIN_SCK]  = sck_pin;
    assign pins_raw[PIN_CS]   = cs_n_pin;
    assign pins_raw[PIN_HOLD] = hold_n_pin;

    pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    pin_edge #(.W(PIN_W), .RST_VAL(PIN_IDLE)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (pins_s),
        .rise (pins_r),
        .fall (pins_f)
    );

    assign hold_s = pins_s[PIN_HOLD];
    assign cs_n_s = pins_s[PIN_CS];
    assign sck_s  = pins_s[PIN_SCK];

    pause_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_lvl (cs_n_s),
        .sck_lvl  (sck_s),
        .hold_rise(pins_r[PIN_HOLD]),
        .hold_fall(pins_f[PIN_HOLD]),
        .sck_fall (pins_f[PIN_SCK]),
        .cs_fall  (pins_f[PIN_CS]),
        .held     (held),
        .state    (state)
    );

    logic live;
    assign live = (state != PS_IDLE) && !cs_n_s && !held;

    assign pause_on    = held;
    assign do_hiz      = !live;
    assign sck_rise_en = live && pins_r[PIN_SCK];
    assign sck_fall_en = live && pins_f[PIN_SCK];
    assign sel_drop    = pins_r[PIN_CS];
endmodule

// File: rtl/pause_ctrl_chk.sv
module pause_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic pause_on,
    input logic sck_rise_en,
    input logic sck_fall_en,
    input logic sel_drop,
    input logic hold_s,
    input logic cs_n_s
);
    // R7
    held_blocks_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_on |-> !(sck_rise_en || sck_fall_en));

    // R10
    drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_drop |-> !pause_on);

    // R10
    drop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_drop |=> !sel_drop);

    // R2
    desel_no_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |-> !pause_on);

    // R3
    pause_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_on) |-> !hold_s);

    // R5
    pause_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pause_on) && !cs_n_s) |-> hold_s);
endmodule

bind pause_ctrl pause_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pause_on   (pause_on),
    .sck_rise_en(sck_rise_en),
    .sck_fall_en(sck_fall_en),
    .sel_drop   (sel_drop),
    .hold_s     (hold_s),
    .cs_n_s     (cs_n_s)
);

// File: tb/sim_pause_ctrl.sv
`timescale 1ns/1ps
module sim_pause_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_n_pin = 1'b1;
    logic cs_n_pin = 1'b1;
    logic sck_pin = 1'b0;
    logic pause_on, do_hiz, sck_rise_en, sck_fall_en, sel_drop;

    int total = 0;
    int bad = 0;
    int n_rise = 0;
    int n_fall = 0;
    int n_drop = 0;
    int n_drop_held = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pause_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .hold_n_pin(hold_n_pin), .cs_n_pin(cs_n_pin),
        .sck_pin(sck_pin), .pause_on(pause_on), .do_hiz(do_hiz),
        .sck_rise_en(sck_rise_en), .sck_fall_en(sck_fall_en), .sel_drop(sel_drop)
    );

    always @(negedge clk) begin
        if (sck_rise_en) n_rise++;
        if (sck_fall_en) n_fall++;
        if (sel_drop) begin
            n_drop++;
            if (pause_on) n_drop_held++;
        end
    end

    // {hold_n, cs_n, sck, exp_pause, exp_hiz, req}
    typedef struct packed {
        logic       h;
        logic       c;
        logic       s;
        logic       ep;
        logic       ez;
        logic [7:0] req;
    } vec_t;
    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1 },  // R1
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd2 },  // R2
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd2 },  // R2
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd11},  // R11
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd3 },  // R3
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd7 },  // R7
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd7 },  // R7
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5 },  // R5
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd11},  // R11
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd4 },  // R4
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd4 },  // R4
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd7 },  // R7
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd6 },  // R6
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6 },  // R6
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd3 },  // R3
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd10},  // R10
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd12},  // R12
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd12}   // R12
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pins(input logic h, input logic c, input logic s);
        hold_n_pin = h;
        cs_n_pin = c;
        sck_pin = s;
        settle(6);
    endtask

    task automatic clear_counts();
        n_rise = 0;
        n_fall = 0;
        n_drop = 0;
        n_drop_held = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        settle(3);
        // R1 reset state
        check("R1 pause_on", int'(pause_on), 0);
        check("R1 do_hiz", int'(do_hiz), 1);
        rst_n = 1'b1;
        settle(6);
        check("R1 no events", n_rise + n_fall + n_drop, 0);

        for (int i = 0; i < NV; i++) begin
            pins(VT[i].h, VT[i].c, VT[i].s);
            check($sformatf("R%0d vec%0d pause_on", VT[i].req, i), int'(pause_on), int'(VT[i].ep));
            check($sformatf("R%0d vec%0d do_hiz", VT[i].req, i), int'(do_hiz), int'(VT[i].ez));
        end

        // R11 running: three clock pulses forwarded one for one
        pins(1, 0, 0);
        clear_counts();
        for (int k = 0; k < 3; k++) begin
            pins(1, 0, 1);
            pins(1, 0, 0);
        end
        check("R11 rise count", n_rise, 3);
        check("R11 fall count", n_fall, 3);

        // R7 paused: clock activity swallowed
        pins(0, 0, 0);
        clear_counts();
        for (int k = 0; k < 3; k++) begin
            pins(0, 0, 1);
            pins(0, 0, 0);
        end
        check("R7 rise count", n_rise, 0);
        check("R7 fall count", n_fall, 0);
        pins(1, 0, 0);

        // R4 deferred entry: the triggering fall still forwarded
        pins(1, 0, 1);
        pins(0, 0, 1);
        clear_counts();
        pins(0, 0, 0);
        check("R4 entry fall forwarded", n_fall, 1);
        check("R4 paused after fall", int'(pause_on), 1);

        // R6 deferred exit: the triggering fall swallowed
        pins(0, 0, 1);
        pins(1, 0, 1);
        check("R6 still paused", int'(pause_on), 1);
        clear_counts();
        pins(1, 0, 0);
        check("R6 exit fall swallowed", n_fall, 0);
        check("R6 resumed", int'(pause_on), 0);

        // R8 cancel a pending entry
        pins(1, 0, 1);
        pins(0, 0, 1);
        pins(1, 0, 1);
        pins(1, 0, 0);
        check("R8 cancelled entry", int'(pause_on), 0);

        // R9 pending exit aborted by new fall
        pins(0, 0, 0);
        pins(0, 0, 1);
        pins(1, 0, 1);
        pins(0, 0, 1);
        pins(0, 0, 0);
        check("R9 still paused", int'(pause_on), 1);

        // R10 deselect while paused
        clear_counts();
        pins(0, 1, 0);
        check("R10 one drop pulse", n_drop, 1);
        check("R10 clear in drop cycle", n_drop_held, 0);
        check("R10 pause cleared", int'(pause_on), 0);

        // R12 select with pause pin low, then a real fall
        pins(0, 0, 0);
        check("R12 no pause on select", int'(pause_on), 0);
        pins(1, 0, 0);
        pins(0, 0, 0);
        check("R12 later fall pauses", int'(pause_on), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule